// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

This block is a register-mapped parallel port. It holds several ports of up to eight pins each. A small synchronous register bus reaches them through an address, write data, a write strobe and combinational read data. Each port has a direction register and a data latch. Each pin presents an output value and an output enable toward its pad, and takes a pad level back in through a two-flop synchroniser.

Software can preload the data latch while a pin is still an input, then switch the pin to output. The preloaded level appears on the pad in the same cycle the enable rises. Reset returns every pin to input, but it leaves the data latch untouched. Any individual pin can be handed to an on-chip peripheral through a per-pin override. While the override is set, the peripheral owns that pin's enable and value. Ports may be narrower than eight bits, and the bits they lack are inert.

Top module: `gpio_port`

## Requirements
- R1: With its override clear, a pin's output enable equals its direction bit: 1 drives the pin and 0 leaves it an input.
- R2: Reset clears every direction bit, so no pin drives. The data latch keeps the value it held before reset.
- R3: A read of a data register returns the synchronised pad level for input bits and the latched value for output bits. A read of a direction register returns the direction bits.
- R4: A data write to an input bit changes the latch without enabling the pin. When the direction bit is later set, the pin drives the preloaded value in the same cycle its enable rises.
- R5: Port n's data register is at address n and its direction register is at address NUM_PORTS+n. With the default of 4 ports, the third port's data register is at 0x2 and its direction register at 0x6.
- R6: Bits that a narrow port does not implement read as 0, ignore writes, and never drive. By default ports 0 and 2 have 8 bits, port 1 has 6 bits and port 3 has 4 bits, in the low positions.
- R7: A pad level change becomes visible on a data read after exactly two clock edges, and not after one.
- R8: With a pin's override set, the peripheral's enable and value drive that pin whatever its direction bit says, and a data read of that bit returns the synchronised pad level.
- R9: Reads of unmapped addresses (2*NUM_PORTS and above) return 0, and writes to them change no pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Register address |
| wrData | input | 8 | Write data |
| wrEn | input | 1 | Write strobe, sampled on the rising edge |
| rdData | output | 8 | Combinational read data for `addr` |
| pinIn | input | NUM_PORTS*8 | Pad levels, port n in bits [8n+7:8n] |
| altEn | input | NUM_PORTS*8 | Per-pin peripheral override |
| altOut | input | NUM_PORTS*8 | Peripheral output value |
| altOe | input | NUM_PORTS*8 | Peripheral output enable |
| pinOut | output | NUM_PORTS*8 | Value toward the pads |
| pinOe | output | NUM_PORTS*8 | Output enable toward the pads |

## Verification
The bench sweeps every port through a range of direction, latch and pad patterns and checks the read-back mixing bit by bit. A mixing error, such as returning the latch for input bits, would show as wrong read data. It preloads the latch before it sets the direction and checks the pad value in the cycle the enable rises. A design that cleared the latch on reset, or that only loaded it for output bits, would drive the wrong level there. Other checks count synchroniser edges, since a one-flop or three-flop path moves the change by one cycle. Further checks cover the missing bits of narrow ports, overrides that must also win over read-back, and stray writes to unmapped addresses that must alias onto no real register.

// File: rtl/gpio_pkg.sv
`timescale 1ns/1ps
package gpio_pkg;
  localparam int MAX_PORTS = 16;
  localparam int PORT_W    = 8;

  typedef struct packed {
    logic [MAX_PORTS-1:0] dataWe;  // load data latch of port n
    logic [MAX_PORTS-1:0] dirWe;   // load direction register of port n
    logic [MAX_PORTS-1:0] rdSel;   // port n selected for read
    logic                 rdIsDir; // selected register is a direction register
  } gpioStrobes_t;
endpackage

// File: rtl/gpio_ctrl.sv
`timescale 1ns/1ps
module gpio_ctrl
  import gpio_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int ADDR_W    = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  output gpioStrobes_t      strb
);
  localparam int DIR_BASE = NUM_PORTS;

  always_comb begin
    strb = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (addr == ADDR_W'(p)) begin
        strb.dataWe[p] = wrEn;
        strb.rdSel[p]  = 1'b1;
      end
      if (addr == ADDR_W'(DIR_BASE + p)) begin
        strb.dirWe[p]  = wrEn;
        strb.rdSel[p]  = 1'b1;
        strb.rdIsDir   = 1'b1;
      end
    end
  end
endmodule

// File: rtl/gpio_bank.sv
`timescale 1ns/1ps
module gpio_bank #(
  parameter int         W    = 8,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         dataWe,
  input  logic         dirWe,
  input  logic [W-1:0] wrData,
  input  logic [W-1:0] pinIn,
  input  logic [W-1:0] altEn,
  input  logic [W-1:0] altOut,
  input  logic [W-1:0] altOe,
  output logic [W-1:0] dataRd,
  output logic [W-1:0] dirRd,
  output logic [W-1:0] pinOut,
  output logic [W-1:0] pinOe
);
  logic [W-1:0] dirQ, latchQ, metaQ, syncQ, own;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dirQ <= '0;
    else if (dirWe) dirQ <= wrData & MASK;
  end

  // data latch deliberately has no reset
  always_ff @(posedge clk) begin
    if (dataWe) latchQ <= wrData & MASK;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      metaQ <= '0;
      syncQ <= '0;
    end else begin
      metaQ <= pinIn & MASK;
      syncQ <= metaQ;
    end
  end

  assign own    = altEn & MASK;
  assign pinOe  = ((own & altOe)  | (~own & dirQ))   & MASK;
  assign pinOut = ((own & altOut) | (~own & latchQ)) & MASK;
  assign dataRd = ((dirQ & ~own & latchQ) | ((~dirQ | own) & syncQ)) & MASK;
  assign dirRd  = dirQ;
endmodule

// File: rtl/gpio_datapath.sv
`timescale 1ns/1ps
module gpio_datapath
  import gpio_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter logic [NUM_PORTS*PORT_W-1:0] PIN_MASK = '1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  gpioStrobes_t                  strb,
  input  logic [PORT_W-1:0]             wrData,
  output logic [PORT_W-1:0]             rdData,
  input  logic [NUM_PORTS*PORT_W-1:0]   pinIn,
  input  logic [NUM_PORTS*PORT_W-1:0]   altEn,
  input  logic [NUM_PORTS*PORT_W-1:0]   altOut,
  input  logic [NUM_PORTS*PORT_W-1:0]   altOe,
  output logic [NUM_PORTS*PORT_W-1:0]   pinOut,
  output logic [NUM_PORTS*PORT_W-1:0]   pinOe
);
  logic [PORT_W-1:0] dataRdA [NUM_PORTS];
  logic [PORT_W-1:0] dirRdA  [NUM_PORTS];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_bank
    gpio_bank #(
      .W   (PORT_W),
      .MASK(PIN_MASK[p*PORT_W +: PORT_W])
    ) u_bank (
      .clk   (clk),
      .rstN  (rstN),
      .dataWe(strb.dataWe[p]),
      .dirWe (strb.dirWe[p]),
      .wrData(wrData),
      .pinIn (pinIn [p*PORT_W +: PORT_W]),
      .altEn (altEn [p*PORT_W +: PORT_W]),
      .altOut(altOut[p*PORT_W +: PORT_W]),
      .altOe (altOe [p*PORT_W +: PORT_W]),
      .dataRd(dataRdA[p]),
      .dirRd (dirRdA[p]),
      .pinOut(pinOut[p*PORT_W +: PORT_W]),
      .pinOe (pinOe [p*PORT_W +: PORT_W])
    );
  end

  always_comb begin
    rdData = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (strb.rdSel[p]) rdData |= strb.rdIsDir ? dirRdA[p] : dataRdA[p];
    end
  end
endmodule

// File: rtl/gpio_port.sv
`timescale 1ns/1ps
module gpio_port
  import gpio_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int ADDR_W    = 4,
  parameter logic [NUM_PORTS*8-1:0] PIN_MASK = 32'h0FFF3FFF
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [7:0]             wrData,
  input  logic                   wrEn,
  output logic [7:0]             rdData,
  input  logic [NUM_PORTS*8-1:0] pinIn,
  input  logic [NUM_PORTS*8-1:0] altEn,
  input  logic [NUM_PORTS*8-1:0] altOut,
  input  logic [NUM_PORTS*8-1:0] altOe,
  output logic [NUM_PORTS*8-1:0] pinOut,
  output logic [NUM_PORTS*8-1:0] pinOe
);
  gpioStrobes_t strb;

  gpio_ctrl #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)) u_ctrl (
    .addr(addr),
    .wrEn(wrEn),
    .strb(strb)
  );

  gpio_datapath #(.NUM_PORTS(NUM_PORTS), .PIN_MASK(PIN_MASK)) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .wrData(wrData),
    .rdData(rdData),
    .pinIn (pinIn),
    .altEn (altEn),
    .altOut(altOut),
    .altOe (altOe),
    .pinOut(pinOut),
    .pinOe (pinOe)
  );
endmodule

// File: rtl/gpio_port_chk.sv
`timescale 1ns/1ps
module gpio_port_chk #(
  parameter int NUM_PORTS = 4,
  parameter logic [NUM_PORTS*8-1:0] PIN_MASK = '1
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   wrEn,
  input logic [NUM_PORTS*8-1:0] altEn,
  input logic [NUM_PORTS*8-1:0] altOut,
  input logic [NUM_PORTS*8-1:0] altOe,
  input logic [NUM_PORTS*8-1:0] pinOut,
  input logic [NUM_PORTS*8-1:0] pinOe
);
  AST_RESET_NO_DRIVE: assert property (@(posedge clk)
    !rstN |-> ((pinOe & ~altEn) == '0)); // R2

  AST_UNIMPL_INERT: assert property (@(posedge clk) disable iff (!rstN)
    ((pinOe | pinOut) & ~PIN_MASK) == '0); // R6

  AST_ALT_OWNS_PIN: assert property (@(posedge clk) disable iff (!rstN)
    (((pinOe ^ altOe) | (pinOut ^ altOut)) & altEn & PIN_MASK) == '0); // R8

  AST_DIR_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(wrEn) && $stable(altEn)) |-> $stable(pinOe & ~altEn)); // R1

  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(wrEn) && $stable(altEn)) |-> $stable(pinOut & ~altEn)); // R4
endmodule

bind gpio_port gpio_port_chk #(.NUM_PORTS(NUM_PORTS), .PIN_MASK(PIN_MASK)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .altEn(altEn), .altOut(altOut),
  .altOe(altOe), .pinOut(pinOut), .pinOe(pinOe)
);

// File: tb/tb_gpio_port.sv
`timescale 1ns/1ps
module tb_gpio_port;
  localparam int NP = 4;
  localparam int AW = 4;
  localparam logic [7:0] MSK [NP] = '{8'hFF, 8'h3F, 8'hFF, 8'h0F};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] wrData = '0;
  logic wrEn = 1'b0;
  logic [7:0] rdData;
  logic [NP*8-1:0] pinIn = '0, altEn = '0, altOut = '0, altOe = '0;
  logic [NP*8-1:0] pinOut, pinOe;
  int vecs = 0;
  int errs = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  gpio_port dut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData), .wrEn(wrEn),
    .rdData(rdData), .pinIn(pinIn), .altEn(altEn), .altOut(altOut),
    .altOe(altOe), .pinOut(pinOut), .pinOe(pinOe)
  );

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    vecs++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(int a, logic [7:0] d);
    @(negedge clk);
    addr = AW'(a); wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdChk(string req, int a, logic [7:0] exp);
    addr = AW'(a);
    #1;
    chk(req, {24'h0, rdData}, {24'h0, exp});
  endtask

  task automatic edges(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [NP*8-1:0] oeSave, outSave;
    edges(2);
    chk("R2 no drive in reset", pinOe, '0);
    @(negedge clk) rstN = 1'b1;
    for (int p = 0; p < NP; p++) rdChk("R2 dir reset", NP + p, 8'h00);

    // sweep: R1 R3 R4 R5 R6 over all ports
    for (int p = 0; p < NP; p++) begin
      for (int k = 0; k < 12; k++) begin
        logic [7:0] d, m, pv;
        d  = 8'(k * 53 + 17);
        m  = 8'(k * 29 + p * 7);
        pv = 8'(k * 91 + 3);
        wr(NP + p, 8'h00);
        wr(p, d);
        chk("R4 silent latch", {24'h0, pinOe[p*8 +: 8]}, 32'h0);
        wr(NP + p, m);
        chk("R1 enable", {24'h0, pinOe[p*8 +: 8]}, {24'h0, m & MSK[p]});
        chk("R4 preload", {24'h0, pinOut[p*8 +: 8] & m}, {24'h0, d & m & MSK[p]});
        rdChk("R3 dir read", NP + p, m & MSK[p]);
        pinIn[p*8 +: 8] = pv;
        edges(2);
        rdChk("R3 data mix", p, ((m & d) | (~m & pv)) & MSK[p]);
      end
    end

    // R7 synchroniser depth
    wr(NP, 8'h00);
    pinIn[7:0] = 8'h00;
    edges(3);
    pinIn[7:0] = 8'hA5;
    @(negedge clk);
    rdChk("R7 one edge", 0, 8'h00);
    @(negedge clk);
    rdChk("R7 two edges", 0, 8'hA5);

    // R2 latch retention across reset
    wr(0, 8'h3C);
    wr(NP, 8'hFF);
    chk("R2 before reset", {24'h0, pinOut[7:0]}, 32'h3C);
    @(negedge clk) rstN = 1'b0;
    #1 chk("R2 reset oe", pinOe, '0);
    @(negedge clk) rstN = 1'b1;
    rdChk("R2 dir cleared", NP, 8'h00);
    wr(NP, 8'hFF);
    chk("R2 latch kept", {24'h0, pinOut[7:0]}, 32'h3C);
    chk("R2 re-enable", {24'h0, pinOe[7:0]}, 32'hFF);

    // R6 narrow ports
    wr(1, 8'hFF);
    wr(NP + 1, 8'hFF);
    rdChk("R6 dir mask", NP + 1, 8'h3F);
    chk("R6 oe mask", {24'h0, pinOe[15:8]}, 32'h3F);
    chk("R6 out mask", {24'h0, pinOut[15:8]}, 32'h3F);
    wr(NP + 3, 8'hFF);
    chk("R6 port3 oe", {24'h0, pinOe[31:24]}, 32'h0F);
    wr(NP + 1, 8'h00);
    pinIn[15:8] = 8'hFF;
    edges(2);
    rdChk("R6 input mask", 1, 8'h3F);

    // R8 peripheral override on port 2 bit 3
    wr(NP + 2, 8'hFF);
    wr(2, 8'h00);
    pinIn[23:16] = 8'h08;
    altEn[19] = 1'b1; altOe[19] = 1'b0; altOut[19] = 1'b1;
    #1 chk("R8 alt oe low", {31'h0, pinOe[19]}, 32'h0);
    altOe[19] = 1'b1;
    #1 chk("R8 alt oe high", {31'h0, pinOe[19]}, 32'h1);
    chk("R8 alt out high", {31'h0, pinOut[19]}, 32'h1);
    altOut[19] = 1'b0;
    #1 chk("R8 alt out low", {31'h0, pinOut[19]}, 32'h0);
    edges(2);
    rdChk("R8 read pad", 2, 8'h08);
    pinIn[19] = 1'b0;
    edges(2);
    rdChk("R8 read pad low", 2, 8'h00);
    @(negedge clk);
    altEn[19] = 1'b0;
    #1 chk("R8 release oe", {31'h0, pinOe[19]}, 32'h1);
    chk("R8 release out", {31'h0, pinOut[19]}, 32'h0);

    // R5 address placement of the third port
    oeSave = pinOe;
    wr(6, 8'h55);
    chk("R5 dir at 0x6", {24'h0, pinOe[23:16]}, 32'h55);
    chk("R5 others kept", {pinOe[31:24], pinOe[15:0]}, {oeSave[31:24], oeSave[15:0]});
    wr(2, 8'hAA);
    chk("R5 data at 0x2", {24'h0, pinOut[23:16]}, 32'hAA);

    // R9 unmapped addresses
    oeSave = pinOe;
    outSave = pinOut;
    for (int a = 2 * NP; a < (1 << AW); a++) begin
      wr(a, 8'hFF);
      rdChk("R9 unmapped read", a, 8'h00);
    end
    chk("R9 oe unchanged", pinOe, oeSave);
    chk("R9 out unchanged", pinOut, outSave);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    finished = 1'b1;
    $finish;
  end

  initial begin
    #800000;
    if (!finished) begin
      errs++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule